// File: doc/BRIEF.md
# Vector High-Half Widening Unit

This block decodes and executes a family of eight 128-bit SIMD widening operations. Each operation takes the elements in the upper half of a 128-bit source vector and extends every one to twice its width, so the result fills all 128 bits. Four width pairs are supported: 8 to 16, 16 to 32, 32 to 64 and 64 to 128. Each pair has a signed form, which sign-extends, and an unsigned form, which zero-extends.

The host pipeline presents a 32-bit operation word, the source vector read from its register file, a valid strobe and a vector-enable bit. The block checks the word against a fixed prefix and decodes a 5-bit operation selector. It then returns a registered result, the source and destination register indices, a result-valid strobe and two fault flags: one for an unknown operation and one for an attempt to run while vector execution is off.

Top module: `vhw_top`

## Requirements
- R1: All outputs are registered. They reflect an input beat presented with `inValid` high on the next rising clock edge, and when `inValid` is low on an edge, `outValid`, `illegalOp` and `vecOff` are low after that edge.
- R2: A synchronous active-high `rst` clears `outResult`, `outValid`, `illegalOp`, `vecOff`, `outDst` and `outSrc` to zero.
- R3: A word matches when bits 31:28 are 0111, bits 27:20 are 00101001 and bits 19:15 are 11101. Bits 14:10 hold the operation selector. Values 11000 through 11111 choose, in this order: signed 8→16, signed 16→32, signed 32→64, signed 64→128, unsigned 8→16, unsigned 16→32, unsigned 32→64 and unsigned 64→128.
- R4: For a source element width W, result element i (2W bits wide) is the extension of source element i + 64/W, for i from 0 to 64/W − 1.
- R5: Signed selectors replicate the top bit of each source element into the upper half of the widened element. Unsigned selectors fill that upper half with zeros.
- R6: In the two 64→128 forms, source bits 127:64 are extended to make up the whole 128-bit result.
- R7: On a valid beat, `outSrc` takes word bits 9:5 and `outDst` takes word bits 4:0.
- R8: A valid beat whose word does not match the prefix, or whose selector is below 11000, raises `illegalOp`, keeps `outValid` low and leaves `outResult` at its previous value.
- R9: A valid, well-formed beat with `vecEn` low raises `vecOff`, keeps `outValid` low and leaves `outResult` at its previous value. An ill-formed word takes priority and raises only `illegalOp`.
- R10: `outValid`, `illegalOp` and `vecOff` are never high together. At most one of them is set after any edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operation word and source are valid this cycle |
| inWord | input | 32 | Operation word |
| inVec | input | 128 | Source vector value |
| vecEn | input | 1 | Vector execution enabled |
| outResult | output | 128 | Widened result (holds on faults and idle cycles) |
| outValid | output | 1 | Result written this cycle |
| outDst | output | 5 | Destination register index from the word |
| outSrc | output | 5 | Source register index from the word |
| illegalOp | output | 1 | Word not recognised |
| vecOff | output | 1 | Vector execution disabled fault |

## Verification
The assertions assume that `inValid`, `inWord` and `vecEn` are known and stable around each rising edge, and that one beat is offered per cycle with no back-pressure. The datapath checks assume the selector reaching it has already been decoded as legal. The stimulus drives every input on the falling edge, seeds `$urandom` with a fixed value, and draws selectors from the legal range apart from deliberately corrupted words. Directed patterns set the top bit of every upper-half element, so sign extension and zero extension produce visibly different results.

// File: rtl/vhw_pkg.sv
package vhw_pkg;
  localparam int VecW   = 128;
  localparam int WordW  = 32;
  localparam int RegIdxW = 5;
  localparam int SelW   = 5;

  localparam logic [3:0] PrefixA = 4'b0111;
  localparam logic [7:0] PrefixB = 8'b00101001;
  localparam logic [4:0] PrefixC = 5'b11101;

  typedef enum logic [1:0] {
    SZ8  = 2'd0,
    SZ16 = 2'd1,
    SZ32 = 2'd2,
    SZ64 = 2'd3
  } elemSize_e;

  typedef struct packed {
    logic      load;
    logic      signExt;
    elemSize_e size;
  } dpCtl_t;
endpackage

// File: rtl/vhw_ctrl.sv
module vhw_ctrl
  import vhw_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [WordW-1:0]   inWord,
  input  logic               vecEn,
  output dpCtl_t             dpCtl,
  output logic               outValid,
  output logic               illegalOp,
  output logic               vecOff,
  output logic [RegIdxW-1:0] outDst,
  output logic [RegIdxW-1:0] outSrc
);
  logic           prefixOk;
  logic [SelW-1:0] sel;
  logic           selOk;
  logic           wellFormed;

  assign prefixOk   = (inWord[31:28] == PrefixA) && (inWord[27:20] == PrefixB)
                   && (inWord[19:15] == PrefixC);
  assign sel        = inWord[14:10];
  assign selOk      = (sel[4:3] == 2'b11);
  assign wellFormed = prefixOk && selOk;

  always_comb begin
    dpCtl.load    = inValid && wellFormed && vecEn;
    dpCtl.signExt = ~sel[2];
    dpCtl.size    = elemSize_e'(sel[1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid  <= 1'b0;
      illegalOp <= 1'b0;
      vecOff    <= 1'b0;
      outDst    <= '0;
      outSrc    <= '0;
    end else begin
      outValid  <= inValid && wellFormed && vecEn;
      illegalOp <= inValid && !wellFormed;
      vecOff    <= inValid && wellFormed && !vecEn;
      if (inValid) begin
        outDst <= inWord[4:0];
        outSrc <= inWord[9:5];
      end
    end
  end

  // R10
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({outValid, illegalOp, vecOff}) <= 1);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !(outValid || illegalOp || vecOff));

  // R9
  vec_off_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && !vecEn && !illegalOp && prefixOk && selOk) |=> (vecOff && !outValid));

  // R7
  idx_capture_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> (outDst == $past(inWord[4:0]) && outSrc == $past(inWord[9:5])));
endmodule

// File: rtl/vhw_dp.sv
module vhw_dp
  import vhw_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  dpCtl_t          dpCtl,
  input  logic [VecW-1:0] inVec,
  output logic [VecW-1:0] outResult
);
  localparam int NumSizes = 4;
  localparam int HalfW    = VecW / 2;

  logic [VecW-1:0] widened [NumSizes];

  for (genvar s = 0; s < NumSizes; s++) begin : g_size
    localparam int SrcW  = 8 << s;
    localparam int DstW  = 2 * SrcW;
    localparam int Count = VecW / DstW;
    for (genvar i = 0; i < Count; i++) begin : g_elem
      logic [SrcW-1:0] srcElem;
      assign srcElem = inVec[HalfW + i*SrcW +: SrcW];
      assign widened[s][i*DstW +: DstW] =
        {{SrcW{dpCtl.signExt & srcElem[SrcW-1]}}, srcElem};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) outResult <= '0;
    else if (dpCtl.load) outResult <= widened[dpCtl.size];
  end

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(dpCtl.load) |-> $stable(outResult));

  // R6
  quad_low_chk: assert property (@(posedge clk) disable iff (rst)
    (dpCtl.load && dpCtl.size == SZ64) |=> (outResult[63:0] == $past(inVec[127:64])));

  // R5
  zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (dpCtl.load && !dpCtl.signExt && dpCtl.size == SZ64) |=> (outResult[127:64] == '0));
endmodule

// File: rtl/vhw_top.sv
module vhw_top
  import vhw_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           inValid,
  input  logic [31:0]    inWord,
  input  logic [127:0]   inVec,
  input  logic           vecEn,
  output logic [127:0]   outResult,
  output logic           outValid,
  output logic [4:0]     outDst,
  output logic [4:0]     outSrc,
  output logic           illegalOp,
  output logic           vecOff
);
  dpCtl_t dpCtl;

  vhw_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inWord(inWord), .vecEn(vecEn),
    .dpCtl(dpCtl), .outValid(outValid), .illegalOp(illegalOp), .vecOff(vecOff),
    .outDst(outDst), .outSrc(outSrc)
  );

  vhw_dp u_dp (
    .clk(clk), .rst(rst), .dpCtl(dpCtl), .inVec(inVec), .outResult(outResult)
  );
endmodule

// File: tb/test_vhw_top.sv
module test_vhw_top;
  logic         clk = 1'b0;
  logic         rst;
  logic         inValid;
  logic [31:0]  inWord;
  logic [127:0] inVec;
  logic         vecEn;
  logic [127:0] outResult;
  logic         outValid;
  logic [4:0]   outDst, outSrc;
  logic         illegalOp, vecOff;

  int checks = 0;
  int errors = 0;
  logic [127:0] lastRes = '0;
  bit done = 0;

  always #4 clk = ~clk;

  vhw_top i_vhw_top (.*);

  function automatic logic [127:0] refWiden(input logic [4:0] sel, input logic [127:0] v);
    logic [127:0] r = '0;
    int w = 8 << sel[1:0];
    bit sgn = !sel[2];
    for (int i = 0; i < 64 / w; i++) begin
      for (int b = 0; b < 2 * w; b++) begin
        if (b < w) r[i*2*w + b] = v[64 + i*w + b];
        else       r[i*2*w + b] = sgn & v[64 + i*w + w - 1];
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] mkWord(input logic [4:0] sel, input logic [4:0] src, input logic [4:0] dst);
    return {4'b0111, 8'b00101001, 5'b11101, sel, src, dst};
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive on negedge, sample on following negedge (one posedge between)
  task automatic beat(input logic v, input logic [31:0] w, input logic [127:0] x, input logic en,
                      input string req);
    logic good;
    logic [127:0] expRes;
    inValid = v; inWord = w; inVec = x; vecEn = en;
    @(negedge clk);
    good = (w[31:15] == {4'b0111, 8'b00101001, 5'b11101}) && (w[14:13] == 2'b11);
    expRes = (v && good && en) ? refWiden(w[14:10], x) : lastRes;
    check({req, " valid"}, {127'b0, outValid}, {127'b0, v && good && en});
    check({req, " illegal"}, {127'b0, illegalOp}, {127'b0, v && !good});
    check({req, " vecoff"}, {127'b0, vecOff}, {127'b0, v && good && !en});
    check({req, " result"}, outResult, expRes);
    if (v) check({req, " idx R7"}, {118'b0, outSrc, outDst}, {118'b0, w[9:5], w[4:0]});
    lastRes = expRes;
  endtask

  initial begin
    int seed;
    seed = 32'h1234;
    void'($urandom(seed));
    rst = 1; inValid = 0; inWord = 0; inVec = 0; vecEn = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
    // R2 reset state
    check("R2 result", outResult, '0);
    check("R2 flags", {125'b0, outValid, illegalOp, vecOff}, '0);
    check("R2 idx", {118'b0, outDst, outSrc}, '0);
    // R3 R4 R5 R6: boundary patterns, all eight forms
    for (int s = 24; s < 32; s++) begin
      beat(1, mkWord(5'(s), 5'd3, 5'd7), {64'h8080_8000_8000_0000 | 64'h8888_8888_8888_8888, 64'h0123_4567_89ab_cdef}, 1, "R5 topbit");
      beat(1, mkWord(5'(s), 5'd1, 5'd2), {{64{1'b1}}, 64'h0}, 1, "R6 allones");
      beat(1, mkWord(5'(s), 5'd9, 5'd30), {64'h7f7f_7fff_7fff_ffff, 64'hffff_ffff_ffff_ffff}, 1, "R4 positive");
    end
    // R1 idle cycle
    beat(0, mkWord(5'd24, 0, 0), {128{1'b1}}, 1, "R1 idle");
    // R8 bad prefix and bad selector
    beat(1, mkWord(5'd24, 1, 1) ^ 32'h1000_0000, {128{1'b1}}, 1, "R8 prefix");
    beat(1, mkWord(5'd23, 1, 1), {128{1'b1}}, 1, "R8 selector");
    beat(1, mkWord(5'd0, 1, 1) ^ 32'h0000_8000, {128{1'b1}}, 0, "R9 R8 priority");
    // R9 vector disabled
    beat(1, mkWord(5'd27, 4, 5), {128{1'b1}}, 0, "R9 disabled");
    // R10 random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] w;
      logic [4:0] sel = 5'd24 + 5'($urandom_range(0, 7));
      w = mkWord(sel, 5'($urandom), 5'($urandom));
      if ($urandom_range(0, 9) == 0) w = w ^ (32'h1 << $urandom_range(10, 31));
      beat($urandom_range(0, 7) != 0, w, {$urandom, $urandom, $urandom, $urandom},
           $urandom_range(0, 9) != 0, "R10 random");
    end
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule